// File: doc/BRIEF.md
# Systematic Binary Golay Encoder

This block turns a 12-bit message into a codeword of the perfect binary Golay code with length 23, dimension 12 and minimum distance 7. On request it also produces the 24-bit extended form with minimum distance 8. The 11 check bits are the remainder left when the message, multiplied by x^11, is divided over GF(2) by x^11 + x^9 + x^7 + x^6 + x^5 + x + 1. Written as a 12-bit constant, that divisor is 0xAE3. The data bits pass through to the output unchanged, so the code is systematic.

A producer asserts the strobe for one cycle with the message and a mode bit. The mode bit chooses the plain or the extended form. The division is twelve unrolled conditional-XOR shift steps in combinational logic. On the next clock edge the result is stored in the output register, and the valid flag rises for one cycle. The producer may issue a new message every cycle. There is no backpressure.

Top module: `gly_encoder`

## Requirements
- R1: A synchronous active-high reset sets the output word to zero and drops the valid flag at the next clock edge.
- R2: The valid flag is high in the cycle after each clock edge that samples the strobe high. It is low after each edge that samples the strobe low.
- R3: Output bits [22:11] equal the message sampled with the strobe.
- R4: Output bits [10:0] are the remainder of the message times x^11 divided by 0xAE3, so the 23-bit word in bits [22:0] leaves a zero remainder when divided by 0xAE3.
- R5: With the mode bit at 1 (extended), output bit 23 makes the number of ones in the 24-bit word even.
- R6: With the mode bit at 0 (plain), output bit 23 is 0.
- R7: While the strobe is low, the output word keeps its last value.
- R8: The mode bit is sampled with each strobe on its own, so back-to-back strobes may alternate between the plain and the extended form.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_stb | input | 1 | One-cycle strobe: the message and the mode bit are sampled |
| in_msg | input | 12 | Message to encode |
| in_ext | input | 1 | 1 = 24-bit extended word, 0 = 23-bit plain word |
| out_vld | output | 1 | Output word is new in this cycle |
| out_word | output | 24 | Codeword: data [22:11], check [10:0], parity or zero in [23] |

## Verification
The bench compares the output against hand-derived codewords for single-bit messages and for the all-zero and all-ones messages. A divisor with a tap in the wrong place would corrupt these remainders, and so would a step that feeds back the wrong bit. It then encodes every message in both modes and divides each 23-bit result by 0xAE3. Any division fault leaves a non-zero remainder, and a parity tree that misses a leaf shows up as an odd-weight extended word. Back-to-back strobes with alternating modes expose a mode bit that is held across transactions. Idle cycles and a reset in the middle of the stream catch an output that drifts or a valid flag that sticks.

// File: rtl/gly_pkg.sv
package gly_pkg;
   localparam int          GLY_MSG_W = 12;
   localparam int          GLY_CHK_W = 11;
   localparam logic [11:0] GLY_POLY  = 12'hAE3;

   typedef enum logic {
      GLY_PLAIN = 1'b0,
      GLY_EXT   = 1'b1
   } gly_mode_e;
endpackage

// File: rtl/gly_div_step.sv
// One step of GF(2) long division with the message fed in MSB first.
module gly_div_step #(
   parameter int                 CHK_W   = 11,
   parameter logic [CHK_W-1:0]   POLY_LO = 11'h2E3
) (
   input  logic [CHK_W-1:0] rem_i,
   input  logic             bit_i,
   output logic [CHK_W-1:0] rem_o
);
   logic fb;

   assign fb    = rem_i[CHK_W-1] ^ bit_i;
   assign rem_o = {rem_i[CHK_W-2:0], 1'b0} ^ (fb ? POLY_LO : '0);
endmodule

// File: rtl/gly_remainder.sv
// Unrolled chain of division steps: remainder of msg * x^CHK_W mod POLY.
module gly_remainder #(
   parameter int               MSG_W = 12,
   parameter int               CHK_W = 11,
   parameter logic [CHK_W:0]   POLY  = 12'hAE3
) (
   input  logic [MSG_W-1:0] msg_i,
   output logic [CHK_W-1:0] rem_o
);
   localparam logic [CHK_W-1:0] POLY_LO = POLY[CHK_W-1:0];

   if (POLY[CHK_W] != 1'b1) begin : g_bad_top
      $error("gly_remainder: divisor must have its top term set");
   end
   if (POLY[0] != 1'b1) begin : g_bad_low
      $error("gly_remainder: divisor must have a constant term");
   end
   if (CHK_W < 2) begin : g_bad_w
      $error("gly_remainder: check width must be at least 2");
   end

   logic [MSG_W:0][CHK_W-1:0] chain;

   assign chain[0] = '0;

   for (genvar s = 0; s < MSG_W; s++) begin : g_step
      gly_div_step #(
         .CHK_W   (CHK_W),
         .POLY_LO (POLY_LO)
      ) u_step (
         .rem_i (chain[s]),
         .bit_i (msg_i[MSG_W-1-s]),
         .rem_o (chain[s+1])
      );
   end

   assign rem_o = chain[MSG_W];
endmodule

// File: rtl/gly_parity.sv
// Balanced XOR tree stored as a heap: node k has children 2k+1 and 2k+2.
module gly_parity #(
   parameter int W = 23
) (
   input  logic [W-1:0] d_i,
   output logic         par_o
);
   localparam int LVL = (W > 1) ? $clog2(W) : 0;
   localparam int NP  = 1 << LVL;
   localparam int NN  = 2 * NP - 1;

   if (W < 1) begin : g_bad_w
      $error("gly_parity: width must be positive");
   end

   logic [NN-1:0] node;

   for (genvar i = 0; i < NP; i++) begin : g_leaf
      if (i < W) begin : g_live
         assign node[NP-1+i] = d_i[i];
      end else begin : g_pad
         assign node[NP-1+i] = 1'b0;
      end
   end

   for (genvar k = 0; k < NP - 1; k++) begin : g_inner
      assign node[k] = node[2*k+1] ^ node[2*k+2];
   end

   assign par_o = node[0];
endmodule

// File: rtl/gly_encoder.sv
module gly_encoder
   import gly_pkg::*;
#(
   parameter int                        MSG_W  = GLY_MSG_W,
   parameter int                        CHK_W  = GLY_CHK_W,
   parameter logic [GLY_CHK_W:0]        POLY   = GLY_POLY,
   parameter bit                        EXT_EN = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_stb,
   input  logic [MSG_W-1:0]         in_msg,
   input  logic                     in_ext,
   output logic                     out_vld,
   output logic [MSG_W+CHK_W:0]     out_word
);
   localparam int CW_W  = MSG_W + CHK_W;
   localparam int OUT_W = CW_W + 1;

   if (CHK_W != GLY_CHK_W) begin : g_bad_chk
      $error("gly_encoder: divisor constant sized for a different check width");
   end

   logic [CHK_W-1:0] rem;
   logic [CW_W-1:0]  cw;
   logic             par;
   logic             top_bit;
   gly_mode_e        mode;

   gly_remainder #(
      .MSG_W (MSG_W),
      .CHK_W (CHK_W),
      .POLY  (POLY)
   ) u_rem (
      .msg_i (in_msg),
      .rem_o (rem)
   );

   assign cw = {in_msg, rem};

   if (EXT_EN) begin : g_ext
      gly_parity #(.W(CW_W)) u_par (
         .d_i   (cw),
         .par_o (par)
      );
   end else begin : g_noext
      assign par = 1'b0;
   end

   assign mode    = gly_mode_e'(in_ext);
   assign top_bit = (mode == GLY_EXT) ? par : 1'b0;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_word <= '0;
         out_vld  <= 1'b0;
      end else begin
         out_vld <= in_stb;
         if (in_stb) begin
            out_word <= {top_bit, cw};
         end
      end
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!out_vld && out_word == '0));

   // R2
   vld_rise_chk: assert property (@(posedge clk) disable iff (rst)
      in_stb |=> out_vld);

   // R2
   vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !in_stb |=> !out_vld);

   // R3
   data_pass_chk: assert property (@(posedge clk) disable iff (rst)
      in_stb |=> out_word[CW_W-1:CHK_W] == $past(in_msg));

   // R5
   even_weight_chk: assert property (@(posedge clk) disable iff (rst)
      (in_stb && in_ext && EXT_EN) |=> ((^out_word) == 1'b0));

   // R6
   plain_top_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (in_stb && !in_ext) |=> (out_word[OUT_W-1] == 1'b0));

   // R7
   hold_word_chk: assert property (@(posedge clk) disable iff (rst)
      !in_stb |=> $stable(out_word));
endmodule

// File: tb/tb_gly_encoder.sv
module tb_gly_encoder;
   localparam int          CLK_PERIOD = 10;
   localparam logic [11:0] G          = 12'hAE3;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_stb = 1'b0;
   logic [11:0] in_msg = '0;
   logic        in_ext = 1'b0;
   logic        out_vld;
   logic [23:0] out_word;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gly_encoder dut (
      .clk      (clk),
      .rst      (rst),
      .in_stb   (in_stb),
      .in_msg   (in_msg),
      .in_ext   (in_ext),
      .out_vld  (out_vld),
      .out_word (out_word)
   );

   // {ext, msg, expected word}, worked out by hand
   localparam logic [36:0] VEC [10] = '{
      {1'b0, 12'h000, 24'h000000},
      {1'b1, 12'h000, 24'h000000},
      {1'b0, 12'h001, 24'h000AE3},
      {1'b1, 12'h001, 24'h800AE3},
      {1'b0, 12'h002, 24'h0015C6},
      {1'b1, 12'h002, 24'h8015C6},
      {1'b1, 12'h004, 24'h00216F},
      {1'b0, 12'h003, 24'h001F25},
      {1'b0, 12'hFFF, 24'h7FFFFF},
      {1'b1, 12'hFFF, 24'hFFFFFF}
   };

   function automatic logic [10:0] ref_rem(input logic [22:0] v);
      logic [22:0] w = v;
      for (int i = 22; i >= 11; i--) begin
         if (w[i]) w = w ^ (23'(G) << (i - 11));
      end
      return w[10:0];
   endfunction

   function automatic logic [23:0] ref_word(input logic [11:0] m, input logic e);
      logic [22:0] c = {m, ref_rem({m, 11'b0})};
      return {e & (^c), c};
   endfunction

   task automatic check(input bit ok, input string req, input logic [23:0] act,
                        input logic [23:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   // one strobe, then the result is sampled at the following falling edge
   task automatic send(input logic [11:0] m, input logic e);
      @(negedge clk);
      in_stb = 1'b1; in_msg = m; in_ext = e;
      @(negedge clk);
      in_stb = 1'b0; in_msg = ~m; in_ext = ~e;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 24'h0, 24'h1);
      report();
   end

   initial begin
      logic [23:0] held;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(out_vld == 1'b0, "R1 vld in reset", {23'b0, out_vld}, 24'h0);
      check(out_word == 24'h0, "R1 word in reset", out_word, 24'h0);
      rst = 1'b0;

      // table walk
      for (int i = 0; i < 10; i++) begin
         send(VEC[i][35:24], VEC[i][36]);
         check(out_vld == 1'b1, "R2 vld after strobe", {23'b0, out_vld}, 24'h1);
         check(out_word == VEC[i][23:0], "R4 table codeword", out_word, VEC[i][23:0]);
      end

      // R7: idle cycles hold the word, R2: valid low
      held = out_word;
      repeat (3) begin
         @(negedge clk);
         check(out_vld == 1'b0, "R2 vld idle", {23'b0, out_vld}, 24'h0);
         check(out_word == held, "R7 word held", out_word, held);
      end

      // full sweep in both modes
      for (int e = 0; e < 2; e++) begin
         for (int m = 0; m < 4096; m++) begin
            logic [23:0] exp;
            exp = ref_word(12'(m), e[0]);
            send(12'(m), e[0]);
            check(out_word[22:11] == 12'(m), "R3 data field", out_word, exp);
            check(ref_rem(out_word[22:0]) == 11'h0, "R4 zero remainder", out_word, exp);
            if (e == 1)
               check((^out_word) == 1'b0, "R5 even weight", out_word, exp);
            else
               check(out_word[23] == 1'b0, "R6 plain top bit", out_word, exp);
         end
      end

      // R8: back-to-back strobes with alternating mode
      @(negedge clk);
      for (int k = 0; k < 8; k++) begin
         logic [11:0] m;
         logic        e;
         m = 12'h5A5 ^ 12'(k * 37);
         e = k[0];
         in_stb = 1'b1; in_msg = m; in_ext = e;
         @(negedge clk);
         check(out_vld == 1'b1, "R8 vld back-to-back", {23'b0, out_vld}, 24'h1);
         check(out_word == ref_word(m, e), "R8 alternating mode", out_word, ref_word(m, e));
      end
      in_stb = 1'b0;

      // R1: reset in the middle of the stream
      send(12'hFFF, 1'b1);
      @(negedge clk);
      rst = 1'b1;
      in_stb = 1'b1; in_msg = 12'h123; in_ext = 1'b1;
      @(negedge clk);
      check(out_vld == 1'b0, "R1 vld mid reset", {23'b0, out_vld}, 24'h0);
      check(out_word == 24'h0, "R1 word mid reset", out_word, 24'h0);
      in_stb = 1'b0;
      rst = 1'b0;
      @(negedge clk);
      check(out_vld == 1'b0, "R2 vld after reset", {23'b0, out_vld}, 24'h0);

      report();
   end
endmodule